// File: doc/BRIEF.md
# Transaction Monitor Tap Unit

This unit sits in a processor card's external agent, between the outgoing request path, the incoming packet FIFO and a hardware performance monitor. Every outgoing request gets the monitor's current 4-bit phase tag written into address bits 52 to 49. A small table, indexed by the request's outstanding tag, records whether the request was exclusive (a read-exclusive or an upgrade) and whether its home memory is on another station.

A single engine drains the incoming FIFO. When it moves a response header into the agent latches, it reports the following to the monitor on the same clock edge:
- the header's phase tag;
- its three coherence state bits;
- the exclusive and remote flags recovered from the table;
- a one-cycle pulse for a negative acknowledgement, or for the positive acknowledgement that completes the request.

Uncached word and double-word writes sent by other processors arrive as a header followed by data words. The engine replays them as local-bus write cycles.

The engine has three states. From `ST_IDLE`, popping an uncached-write header takes it to `ST_FETCH`. `ST_FETCH` pops one data word and moves to `ST_DRIVE`. `ST_DRIVE` waits for ready. When ready arrives, a double-word write whose first beat has just finished goes back to `ST_FETCH`; every other write returns to `ST_IDLE`.

Top module: `txn_tap`

## Requirements
- R1: On each clock edge where `req_valid` is high, `out_valid`, `out_tag` and `out_addr` become valid at that edge. `out_addr` equals `req_addr`, except that bits 52..49 carry `mon_phase_in`. In a cycle with no request, all three outputs are zero.
- R2: A FIFO header word has these fields: kind in bits 2..0, state in bits 5..3, phase in bits 9..6, tag in bits 12..10, and local-bus address in bits 44..13. For a response header (kind 1 = ACK, kind 2 = NACK), `mon_phase` carries that header's phase field in the cycle after the pop.
- R3: Each popped NACK header gives exactly one one-cycle `mon_nack` pulse. Each popped ACK header gives exactly one one-cycle `mon_ack` pulse. Both pulses appear in the cycle after the pop.
- R4: For a response header, `mon_global`, `mon_valid` and `mon_nc_hit` come from header bits 3, 4 and 5 respectively.
- R5: For a response, `mon_excl` and `mon_remote` are the exclusive and remote flags stored by the last request with the same tag, provided that entry is live. An ACK retires its entry; a NACK leaves it live. A request that writes the same tag in the same cycle as an ACK wins over the retirement.
- R6: `mon_hdr` is high only in the cycle after a response-header pop. In every other cycle, all monitor outputs are zero. Headers of other kinds, and data words popped while idle, are consumed with no monitor or bus activity.
- R7: An uncached word write (kind 3) is one header plus one data word. A double-word write (kind 4) is one header plus two data words. Each data word, taken from bits 31..0, becomes one `lb_strobe` beat to the header's address. The bus drive is registered, so `lb_strobe` rises on the edge after the data pop.
- R8: `lb_wr` is high from the header pop until the last beat completes. `lb_dw` stays constant while `lb_wr` is high, and equals 1 throughout a double-word operation. `lb_strobe` is high only while `lb_wr` is high.
- R9: While a beat is driven, the next FIFO word is not popped until `lb_rdy` has been seen; the driven data stays stable until then. No data word is fetched while `lb_busy` is high.
- R10: A synchronous `rst` retires every table entry, returns the engine to idle, zeroes all outputs and blocks popping.
- R11: `fifo_pop` is never high while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mon_phase_in | input | 4 | Phase tag from the monitor |
| req_valid | input | 1 | Outgoing request present |
| req_addr | input | 64 | Outgoing request address |
| req_tag | input | 3 | Outstanding-request tag |
| req_excl | input | 1 | Request is read-exclusive or upgrade |
| req_remote | input | 1 | Home memory is off-station |
| out_valid | output | 1 | Tagged request valid |
| out_addr | output | 64 | Address with phase tag inserted |
| out_tag | output | 3 | Tag of the tagged request |
| fifo_empty | input | 1 | Incoming FIFO empty |
| fifo_word | input | 45 | Incoming FIFO head word |
| fifo_is_hdr | input | 1 | Head word is a header |
| fifo_pop | output | 1 | Pop the head word this cycle |
| mon_hdr | output | 1 | Response header latched |
| mon_phase | output | 4 | Phase tag of the response |
| mon_global | output | 1 | Memory hit in global state |
| mon_valid | output | 1 | Memory hit in valid state |
| mon_nc_hit | output | 1 | Served by network cache |
| mon_excl | output | 1 | Original request was exclusive |
| mon_remote | output | 1 | Original request had a remote home |
| mon_ack | output | 1 | Completing acknowledgement pulse |
| mon_nack | output | 1 | Negative acknowledgement pulse |
| lb_rdy | input | 1 | Local bus ready for the current beat |
| lb_busy | input | 1 | Local bus busy, stall fetching |
| lb_wr | output | 1 | Local-bus write held for the operation |
| lb_dw | output | 1 | Double-word operation |
| lb_strobe | output | 1 | Data beat driven |
| lb_addr | output | 32 | Local-bus address |
| lb_data | output | 32 | Local-bus write data |

## Verification
A table entry that is wrong, stale or not retired does not show as an error at once. It appears only when a later response with that tag is popped: `mon_excl` or `mon_remote` is then wrong in the cycle after the pop. For this reason the bench repeats tags, sends ACKs twice and resets between a request and its response. A wrong engine state shows up within one cycle: `fifo_pop` is high when it should not be, or `lb_wr` or `lb_strobe` is wrong. The bench's behavioural model compares every output on every clock, so such an error is reported at the first divergent edge.

// File: rtl/txn_tap_pkg.sv
package txn_tap_pkg;
    localparam int ADDR_W  = 64;
    localparam int PH_W    = 4;
    localparam int PH_LSB  = 49;
    localparam int TAG_W   = 3;
    localparam int LB_AW   = 32;
    localparam int LB_DW   = 32;
    localparam int KIND_W  = 3;
    localparam int ST_W    = 3;
    // header field positions
    localparam int F_KIND  = 0;
    localparam int F_ST    = F_KIND + KIND_W;
    localparam int F_PH    = F_ST + ST_W;
    localparam int F_TAG   = F_PH + PH_W;
    localparam int F_ADDR  = F_TAG + TAG_W;
    localparam int WORD_W  = F_ADDR + LB_AW;
    localparam int ENTRIES = 1 << TAG_W;

    typedef enum logic [KIND_W-1:0] {
        K_NONE = 3'd0,
        K_ACK  = 3'd1,
        K_NACK = 3'd2,
        K_UCW  = 3'd3,
        K_UCDW = 3'd4
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_DRIVE = 2'd2
    } eng_state_e;
endpackage

// File: rtl/txn_tap_tagger.sv
module txn_tap_tagger
    import txn_tap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   mon_phase_in,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [TAG_W-1:0]  out_tag
);
    logic [ADDR_W-1:0] merged;

    always_comb begin
        merged = req_addr;
        merged[PH_LSB +: PH_W] = mon_phase_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_tag   <= '0;
        end else begin
            out_valid <= req_valid;
            out_addr  <= req_valid ? merged : '0;
            out_tag   <= req_valid ? req_tag : '0;
        end
    end

    p_phase_ins_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid && out_addr[PH_LSB +: PH_W] == $past(mon_phase_in));
    p_low_bits_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_addr[PH_LSB-1:0] == $past(req_addr[PH_LSB-1:0]));
endmodule

// File: rtl/txn_tap_table.sv
module txn_tap_table
    import txn_tap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_excl,
    input  logic             wr_remote,
    input  logic             clr_en,
    input  logic [TAG_W-1:0] clr_tag,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_excl,
    output logic             rd_remote
);
    logic [ENTRIES-1:0] live;
    logic [ENTRIES-1:0] excl_q;
    logic [ENTRIES-1:0] rem_q;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                live[i]   <= 1'b0;
                excl_q[i] <= 1'b0;
                rem_q[i]  <= 1'b0;
            end else if (wr_en && wr_tag == TAG_W'(i)) begin
                live[i]   <= 1'b1;
                excl_q[i] <= wr_excl;
                rem_q[i]  <= wr_remote;
            end else if (clr_en && clr_tag == TAG_W'(i)) begin
                live[i]   <= 1'b0;
            end
        end
    end

    assign rd_excl   = live[rd_tag] & excl_q[rd_tag];
    assign rd_remote = live[rd_tag] & rem_q[rd_tag];

    p_retire_r5: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !(wr_en && wr_tag == clr_tag)) |=> !live[$past(clr_tag)]);
    p_install_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> live[$past(wr_tag)]);
endmodule

// File: rtl/txn_tap_engine.sv
module txn_tap_engine
    import txn_tap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic              fifo_is_hdr,
    output logic              fifo_pop,
    output logic [TAG_W-1:0]  look_tag,
    input  logic              look_excl,
    input  logic              look_remote,
    output logic              retire_en,
    output logic              mon_hdr,
    output logic [PH_W-1:0]   mon_phase,
    output logic              mon_global,
    output logic              mon_valid,
    output logic              mon_nc_hit,
    output logic              mon_excl,
    output logic              mon_remote,
    output logic              mon_ack,
    output logic              mon_nack,
    input  logic              lb_rdy,
    input  logic              lb_busy,
    output logic              lb_wr,
    output logic              lb_dw,
    output logic              lb_strobe,
    output logic [LB_AW-1:0]  lb_addr,
    output logic [LB_DW-1:0]  lb_data
);
    eng_state_e state, nxt;
    kind_e      hkind;
    logic       hdr_pop, dw_q, beat_q;
    logic [LB_AW-1:0] addr_q;
    logic [LB_DW-1:0] data_q;

    assign hkind     = kind_e'(fifo_word[F_KIND +: KIND_W]);
    assign look_tag  = fifo_word[F_TAG +: TAG_W];
    assign fifo_pop  = !rst && !fifo_empty &&
                       ((state == ST_IDLE) || (state == ST_FETCH && !lb_busy));
    assign hdr_pop   = fifo_pop && state == ST_IDLE && fifo_is_hdr;
    assign retire_en = hdr_pop && hkind == K_ACK;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (hdr_pop && (hkind == K_UCW || hkind == K_UCDW)) nxt = ST_FETCH;
            ST_FETCH: if (fifo_pop) nxt = ST_DRIVE;
            ST_DRIVE: if (lb_rdy) nxt = (dw_q && !beat_q) ? ST_FETCH : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            mon_hdr    <= 1'b0;
            mon_phase  <= '0;
            mon_global <= 1'b0;
            mon_valid  <= 1'b0;
            mon_nc_hit <= 1'b0;
            mon_excl   <= 1'b0;
            mon_remote <= 1'b0;
            mon_ack    <= 1'b0;
            mon_nack   <= 1'b0;
            dw_q       <= 1'b0;
            beat_q     <= 1'b0;
            addr_q     <= '0;
            data_q     <= '0;
        end else begin
            mon_hdr    <= 1'b0;
            mon_phase  <= '0;
            mon_global <= 1'b0;
            mon_valid  <= 1'b0;
            mon_nc_hit <= 1'b0;
            mon_excl   <= 1'b0;
            mon_remote <= 1'b0;
            mon_ack    <= 1'b0;
            mon_nack   <= 1'b0;
            if (hdr_pop && (hkind == K_ACK || hkind == K_NACK)) begin
                mon_hdr    <= 1'b1;
                mon_phase  <= fifo_word[F_PH +: PH_W];
                mon_global <= fifo_word[F_ST];
                mon_valid  <= fifo_word[F_ST + 1];
                mon_nc_hit <= fifo_word[F_ST + 2];
                mon_excl   <= look_excl;
                mon_remote <= look_remote;
                mon_ack    <= (hkind == K_ACK);
                mon_nack   <= (hkind == K_NACK);
            end
            if (hdr_pop && (hkind == K_UCW || hkind == K_UCDW)) begin
                addr_q <= fifo_word[F_ADDR +: LB_AW];
                dw_q   <= (hkind == K_UCDW);
                beat_q <= 1'b0;
            end
            if (state == ST_FETCH && fifo_pop) data_q <= fifo_word[LB_DW-1:0];
            if (state == ST_DRIVE && lb_rdy)   beat_q <= 1'b1;
        end
    end

    assign lb_wr     = (state != ST_IDLE);
    assign lb_dw     = dw_q && (state != ST_IDLE);
    assign lb_strobe = (state == ST_DRIVE);
    assign lb_addr   = addr_q;
    assign lb_data   = data_q;

    p_pop_empty_r11: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> !fifo_pop);
    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !mon_hdr |-> !(mon_ack || mon_nack || mon_excl || mon_remote ||
                       mon_global || mon_valid || mon_nc_hit) && mon_phase == '0);
    p_one_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        !(mon_ack && mon_nack));
    p_dw_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (lb_wr && $past(lb_wr)) |-> lb_dw == $past(lb_dw));
    p_strobe_in_wr_r8: assert property (@(posedge clk) disable iff (rst)
        lb_strobe |-> lb_wr);
    p_busy_stall_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FETCH && lb_busy) |-> !fifo_pop);
    p_wait_rdy_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRIVE && !lb_rdy) |=> lb_strobe && $stable(lb_data));
endmodule

// File: rtl/txn_tap.sv
module txn_tap
    import txn_tap_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   mon_phase_in,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_excl,
    input  logic              req_remote,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic [TAG_W-1:0]  out_tag,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_word,
    input  logic              fifo_is_hdr,
    output logic              fifo_pop,
    output logic              mon_hdr,
    output logic [PH_W-1:0]   mon_phase,
    output logic              mon_global,
    output logic              mon_valid,
    output logic              mon_nc_hit,
    output logic              mon_excl,
    output logic              mon_remote,
    output logic              mon_ack,
    output logic              mon_nack,
    input  logic              lb_rdy,
    input  logic              lb_busy,
    output logic              lb_wr,
    output logic              lb_dw,
    output logic              lb_strobe,
    output logic [LB_AW-1:0]  lb_addr,
    output logic [LB_DW-1:0]  lb_data
);
    logic [TAG_W-1:0] look_tag;
    logic             look_excl, look_remote, retire_en;

    txn_tap_tagger u_tagger (
        .clk(clk), .rst(rst), .mon_phase_in(mon_phase_in),
        .req_valid(req_valid), .req_addr(req_addr), .req_tag(req_tag),
        .out_valid(out_valid), .out_addr(out_addr), .out_tag(out_tag)
    );

    txn_tap_table u_table (
        .clk(clk), .rst(rst),
        .wr_en(req_valid), .wr_tag(req_tag), .wr_excl(req_excl), .wr_remote(req_remote),
        .clr_en(retire_en), .clr_tag(look_tag),
        .rd_tag(look_tag), .rd_excl(look_excl), .rd_remote(look_remote)
    );

    txn_tap_engine u_engine (
        .clk(clk), .rst(rst),
        .fifo_empty(fifo_empty), .fifo_word(fifo_word), .fifo_is_hdr(fifo_is_hdr),
        .fifo_pop(fifo_pop),
        .look_tag(look_tag), .look_excl(look_excl), .look_remote(look_remote),
        .retire_en(retire_en),
        .mon_hdr(mon_hdr), .mon_phase(mon_phase), .mon_global(mon_global),
        .mon_valid(mon_valid), .mon_nc_hit(mon_nc_hit), .mon_excl(mon_excl),
        .mon_remote(mon_remote), .mon_ack(mon_ack), .mon_nack(mon_nack),
        .lb_rdy(lb_rdy), .lb_busy(lb_busy), .lb_wr(lb_wr), .lb_dw(lb_dw),
        .lb_strobe(lb_strobe), .lb_addr(lb_addr), .lb_data(lb_data)
    );
endmodule

// File: tb/txn_tap_tb_top.sv
`timescale 1ns/1ps
module txn_tap_tb_top;
    import txn_tap_pkg::*;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst = 1'b1;
    logic [PH_W-1:0]   mon_phase_in = '0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [TAG_W-1:0]  req_tag = '0;
    logic              req_excl = 1'b0, req_remote = 1'b0;
    logic              out_valid;
    logic [ADDR_W-1:0] out_addr;
    logic [TAG_W-1:0]  out_tag;
    logic              fifo_empty = 1'b1;
    logic [WORD_W-1:0] fifo_word = '0;
    logic              fifo_is_hdr = 1'b0;
    logic              fifo_pop;
    logic              mon_hdr, mon_global, mon_valid, mon_nc_hit;
    logic              mon_excl, mon_remote, mon_ack, mon_nack;
    logic [PH_W-1:0]   mon_phase;
    logic              lb_rdy = 1'b1, lb_busy = 1'b0;
    logic              lb_wr, lb_dw, lb_strobe;
    logic [LB_AW-1:0]  lb_addr;
    logic [LB_DW-1:0]  lb_data;

    txn_tap dut_i (.*);

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // bench-side FIFO: {is_hdr, word}
    logic [WORD_W:0] fq[$];

    // reference model state
    bit mv[ENTRIES], me[ENTRIES], mr[ENTRIES];
    int ms;
    bit m_dw, m_beat;
    logic [LB_AW-1:0] m_addr;
    logic [LB_DW-1:0] m_data;
    logic [ADDR_W-1:0] e_oa;
    logic [TAG_W-1:0]  e_ot;
    logic [PH_W-1:0]   e_ph;
    bit e_ov, e_hdr, e_g, e_v, e_nc, e_ex, e_rm, e_ack, e_nack;
    bit pop_seen;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [WORD_W:0] mk_hdr(input int kind, input int st, input int ph,
                                              input int tag, input logic [31:0] a);
        logic [WORD_W-1:0] w;
        w = '0;
        w[F_KIND +: KIND_W] = KIND_W'(kind);
        w[F_ST +: ST_W]     = ST_W'(st);
        w[F_PH +: PH_W]     = PH_W'(ph);
        w[F_TAG +: TAG_W]   = TAG_W'(tag);
        w[F_ADDR +: LB_AW]  = a;
        return {1'b1, w};
    endfunction

    function automatic logic [WORD_W:0] mk_data(input logic [31:0] d);
        logic [WORD_W-1:0] w;
        w = '0;
        w[LB_DW-1:0] = d;
        w[WORD_W-1:LB_DW] = '1;   // upper bits must be ignored
        return {1'b0, w};
    endfunction

    task automatic model_step(output bit exp_pop);
        logic [WORD_W-1:0] w;
        int kind, tg;
        bit ex, rm;
        exp_pop = 1'b0;
        e_hdr = 0; e_ph = '0; e_g = 0; e_v = 0; e_nc = 0;
        e_ex = 0; e_rm = 0; e_ack = 0; e_nack = 0;
        if (rst) begin
            foreach (mv[i]) begin mv[i] = 0; me[i] = 0; mr[i] = 0; end
            ms = 0; m_dw = 0; m_beat = 0; m_addr = '0; m_data = '0;
            e_ov = 0; e_oa = '0; e_ot = '0;
            return;
        end
        w = fifo_word;
        exp_pop = !fifo_empty && (ms == 0 || (ms == 1 && !lb_busy));
        kind = int'(w[F_KIND +: KIND_W]);
        tg   = int'(w[F_TAG +: TAG_W]);
        ex = mv[tg] && me[tg];
        rm = mv[tg] && mr[tg];
        if (ms == 0) begin
            if (exp_pop && fifo_is_hdr) begin
                if (kind == 1 || kind == 2) begin
                    e_hdr = 1; e_ph = w[F_PH +: PH_W];
                    e_g = w[F_ST]; e_v = w[F_ST+1]; e_nc = w[F_ST+2];
                    e_ex = ex; e_rm = rm;
                    e_ack = (kind == 1); e_nack = (kind == 2);
                    if (kind == 1) mv[tg] = 0;
                end else if (kind == 3 || kind == 4) begin
                    m_addr = w[F_ADDR +: LB_AW];
                    m_dw = (kind == 4); m_beat = 0; ms = 1;
                end
            end
        end else if (ms == 1) begin
            if (exp_pop) begin m_data = w[LB_DW-1:0]; ms = 2; end
        end else begin
            if (lb_rdy) begin
                if (m_dw && !m_beat) begin m_beat = 1; ms = 1; end
                else ms = 0;
            end
        end
        e_ov = req_valid;
        e_oa = '0; e_ot = '0;
        if (req_valid) begin
            e_oa = req_addr;
            e_oa[PH_LSB +: PH_W] = mon_phase_in;
            e_ot = req_tag;
            mv[req_tag] = 1; me[req_tag] = req_excl; mr[req_tag] = req_remote;
        end
    endtask

    // one clock: starts and ends at a falling edge
    task automatic cyc();
        bit ep;
        fifo_empty  = (fq.size() == 0);
        fifo_word   = fifo_empty ? '0 : fq[0][WORD_W-1:0];
        fifo_is_hdr = fifo_empty ? 1'b0 : fq[0][WORD_W];
        #8;
        model_step(ep);
        chk("R9/R11 fifo_pop", 64'(fifo_pop), 64'(ep));
        pop_seen = fifo_pop;
        @(posedge clk);
        #10;
        chk("R1 out_valid", 64'(out_valid), 64'(e_ov));
        chk("R1 out_addr", out_addr, e_oa);
        chk("R1 out_tag", 64'(out_tag), 64'(e_ot));
        chk("R6 mon_hdr", 64'(mon_hdr), 64'(e_hdr));
        chk("R2 mon_phase", 64'(mon_phase), 64'(e_ph));
        chk("R3 mon_ack", 64'(mon_ack), 64'(e_ack));
        chk("R3 mon_nack", 64'(mon_nack), 64'(e_nack));
        chk("R4 state bits", 64'({mon_nc_hit, mon_valid, mon_global}), 64'({e_nc, e_v, e_g}));
        chk("R5 mon_excl", 64'(mon_excl), 64'(e_ex));
        chk("R5 mon_remote", 64'(mon_remote), 64'(e_rm));
        chk("R8 lb_wr", 64'(lb_wr), 64'(ms != 0));
        chk("R8 lb_dw", 64'(lb_dw), 64'(m_dw && ms != 0));
        chk("R7 lb_strobe", 64'(lb_strobe), 64'(ms == 2));
        chk("R7 lb_addr", 64'(lb_addr), 64'(m_addr));
        chk("R7 lb_data", 64'(lb_data), 64'(m_data));
        if (pop_seen && fq.size() > 0) void'(fq.pop_front());
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic request(input int tag, input bit ex, input bit rm, input int ph,
                           input logic [63:0] a);
        req_valid = 1; req_tag = TAG_W'(tag); req_excl = ex; req_remote = rm;
        mon_phase_in = PH_W'(ph); req_addr = a;
        cyc();
        req_valid = 0;
    endtask

    task automatic check_reset_outputs();
        chk("R10 reset out_valid", 64'(out_valid), 64'd0);
        chk("R10 reset mon_hdr", 64'(mon_hdr), 64'd0);
        chk("R10 reset lb_wr", 64'(lb_wr), 64'd0);
        chk("R10 reset lb_strobe", 64'(lb_strobe), 64'd0);
        chk("R10 reset fifo_pop", 64'(fifo_pop), 64'd0);
    endtask

    initial begin
        @(negedge clk);
        rst = 1;
        run(3);
        check_reset_outputs();
        rst = 0;
        run(2);

        // R1: phase insertion, several patterns
        request(0, 1, 0, 4'hA, 64'hFFFF_FFFF_FFFF_FFFF);
        request(1, 0, 1, 4'h5, 64'h0000_0000_1234_5678);
        request(2, 1, 1, 4'h0, 64'h001E_0000_0000_0040);
        request(3, 0, 0, 4'hF, 64'h0);
        run(2);

        // R3/R5: NACK keeps entry, ACK retires it, second ACK reports no flags
        fq.push_back(mk_hdr(2, 3'b001, 7, 1, 0));
        fq.push_back(mk_hdr(1, 3'b010, 7, 1, 0));
        fq.push_back(mk_data(32'h1111_2222));
        fq.push_back(mk_hdr(1, 3'b100, 3, 0, 0));
        fq.push_back(mk_hdr(1, 3'b111, 3, 0, 0));
        fq.push_back(mk_hdr(1, 3'b011, 9, 2, 0));
        run(10);

        // R6: unknown kinds are consumed silently
        fq.push_back(mk_hdr(0, 3'b111, 15, 3, 32'hDEAD_0000));
        fq.push_back(mk_hdr(6, 3'b111, 15, 3, 32'hDEAD_0000));
        run(4);

        // R7/R9: word write with delayed ready
        lb_rdy = 0;
        fq.push_back(mk_hdr(3, 0, 0, 0, 32'h0000_1000));
        fq.push_back(mk_data(32'hCAFE_0001));
        fq.push_back(mk_hdr(2, 0, 1, 3, 0));
        run(6);
        lb_rdy = 1;
        run(4);

        // R8/R9: double-word write, busy stalls the second fetch
        fq.push_back(mk_hdr(4, 0, 0, 0, 32'h0000_2000));
        fq.push_back(mk_data(32'hAAAA_0001));
        fq.push_back(mk_data(32'hAAAA_0002));
        lb_rdy = 0;
        run(3);
        lb_busy = 1; lb_rdy = 1;
        run(4);
        lb_busy = 0;
        run(6);

        // R5: request and ACK for the same tag in one cycle
        request(5, 1, 1, 2, 64'h100);
        fq.push_back(mk_hdr(1, 0, 2, 5, 0));
        request(5, 0, 1, 2, 64'h200);
        run(2);
        fq.push_back(mk_hdr(1, 0, 2, 5, 0));
        run(3);

        // R10: reset mid-replay and between request and response
        request(6, 1, 1, 1, 64'h300);
        lb_rdy = 0;
        fq.push_back(mk_hdr(4, 0, 0, 0, 32'h0000_3000));
        fq.push_back(mk_data(32'hBBBB_0001));
        fq.push_back(mk_data(32'hBBBB_0002));
        run(3);
        rst = 1;
        cyc();
        check_reset_outputs();
        rst = 0;
        lb_rdy = 1;
        run(3);
        fq.push_back(mk_hdr(1, 0, 1, 6, 0));
        run(3);

        // mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            req_valid = (r < 40);
            req_tag = TAG_W'($urandom);
            req_excl = 1'($urandom); req_remote = 1'($urandom);
            mon_phase_in = PH_W'($urandom);
            req_addr = {$urandom, $urandom};
            lb_rdy = ($urandom_range(0, 3) != 0);
            lb_busy = ($urandom_range(0, 3) == 0);
            if (fq.size() < 4 && $urandom_range(0, 2) == 0) begin
                int k;
                k = int'($urandom_range(0, 5));
                fq.push_back(mk_hdr(k, int'($urandom_range(0, 7)), int'($urandom_range(0, 15)),
                                    int'($urandom_range(0, 7)), $urandom));
                if (k == 3 || k == 4) fq.push_back(mk_data($urandom));
                if (k == 4 || k == 1) fq.push_back(mk_data($urandom));
            end
            cyc();
        end
        req_valid = 0; lb_rdy = 1; lb_busy = 0;
        run(20);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule